// File: doc/BRIEF.md
# PRBS7 Pattern Generator and Checker

This block is a dual-purpose test-pattern engine that runs on a bit clock. In generator mode it drives a PRBS7 sequence (polynomial x^7 + x^6 + 1) onto its serial output, one bit per clock. In checker mode it follows an incoming serial stream, predicts each bit from the seven bits before it, and reports every mismatch on the same serial output as a short burst of two high pulses.

The two modes cannot run at once. A 3-bit test-enable field must hold the code 5. A 3-bit function-select field then chooses the checker (4) or the generator (1). Every other combination parks the block: the output stays low and the mode-valid flag drops. The generator waits for a start control bit that has been written high and then low, and a later high-then-low write restarts it from its seed.

Top module: `prbs7_pattern_unit`

## Requirements
- R1: `mode_ok_o` is high exactly when `test_en_i` equals 5 and `func_sel_i` equals 1 or 4. It is combinational from those two fields.
- R2: When `mode_ok_o` is low, `tx_bit_o` is low.
- R3: In generator mode (`test_en_i`=5, `func_sel_i`=1), `tx_bit_o` stays low until `start_ctl_i` is sampled high at one rising edge and low at the next. A high level alone or a rising transition alone starts nothing.
- R4: On the edge where that falling transition is sampled, the generator seeds its 7-bit history with all ones (default `SEED`) and outputs 0 for the following cycle. From the next edge on, each output bit equals the bit emitted 6 cycles earlier XOR the bit emitted 7 cycles earlier, with the seed standing in for the bits before the start.
- R5: While generator mode is held, the output sequence repeats with a period of 127 bits.
- R6: Another high-then-low write of `start_ctl_i` during generation restarts the sequence from the seed, with the same timing as R4.
- R7: In checker mode (`test_en_i`=5, `func_sel_i`=4), the first 7 bits received after entering the mode are only loaded as history. Each later bit is an error when it differs from the XOR of the received bits 6 and 7 positions before it.
- R8: An error sampled at an edge while the checker is idle makes `tx_bit_o` high in the next cycle, low in the cycle after, high in the third cycle, and then low for at least one cycle.
- R9: Errors detected while a pulse pair is in progress are counted and not lost. Each one produces its own pulse pair after the current one ends and a one-cycle low gap, up to 2^`PEND_W`-1 queued errors.
- R10: Leaving checker mode clears the history fill, the queued errors and any pulse in progress. `tx_bit_o` is low in the first cycle after checker mode is re-entered.
- R11: Leaving generator mode stops the generator. After generator mode is re-entered, the output is low until a new start write (R3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_i | input | 1 | Serial data to be checked |
| test_en_i | input | 3 | Test-enable field; must be 5 for either mode |
| func_sel_i | input | 3 | Function select: 1 generator, 4 checker |
| start_ctl_i | input | 1 | Generator start control; a high-then-low write starts the pattern |
| tx_bit_o | output | 1 | Generated pattern bit, or error pulses in checker mode |
| mode_ok_o | output | 1 | High when the control fields select a valid mode |

## Verification
A corrupted generator history does not stay hidden. It breaks the recurrence within seven output bits and, because the recurrence cycles, it shifts the whole later sequence, so a bit-exact comparison catches it within a few cycles. In the checker, a wrong fill count or history shows up as pulses that are missing or spurious, starting with the eighth received bit. A lost queued error shows up as a missing pulse pair right after the current pair ends. A stale pulse state shows up as a high output in the first cycle after the mode is re-entered.

// File: rtl/prbs7_pkg.sv
package prbs7_pkg;

    localparam int FIELD_W  = 3;
    localparam int LFSR_W   = 7;

    localparam logic [FIELD_W-1:0] TEST_ENABLE_CODE = 3'd5;
    localparam logic [FIELD_W-1:0] SEL_GEN_CODE     = 3'd1;
    localparam logic [FIELD_W-1:0] SEL_CHK_CODE     = 3'd4;

    // Decoded operating mode; at most one bit is ever set.
    typedef struct packed {
        logic gen_on;
        logic chk_on;
    } mode_sel_t;

    // Error pulse sequencer phases.
    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_HIGH1 = 2'd1,
        PS_GAP   = 2'd2,
        PS_HIGH2 = 2'd3
    } pulse_phase_t;

    // History register: bit k holds the bit seen k+1 cycles ago.
    // Taps for x^7 + x^6 + 1 are the bits 7 and 6 cycles back.
    function automatic logic prbs7_predict(input logic [LFSR_W-1:0] hist);
        return hist[LFSR_W-1] ^ hist[LFSR_W-2];
    endfunction

    function automatic logic [LFSR_W-1:0] prbs7_shift(input logic [LFSR_W-1:0] hist,
                                                       input logic            new_bit);
        return {hist[LFSR_W-2:0], new_bit};
    endfunction

endpackage

// File: rtl/prbs7_mode_dec.sv
module prbs7_mode_dec
    import prbs7_pkg::*;
(
    input  logic [FIELD_W-1:0] test_en_i,
    input  logic [FIELD_W-1:0] func_sel_i,
    output mode_sel_t          mode_o
);

    logic enabled;

    always_comb begin
        enabled       = (test_en_i == TEST_ENABLE_CODE);
        mode_o.gen_on = enabled && (func_sel_i == SEL_GEN_CODE);
        mode_o.chk_on = enabled && (func_sel_i == SEL_CHK_CODE);
    end

endmodule

// File: rtl/prbs7_gen.sv
module prbs7_gen
    import prbs7_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic restart_i,
    output logic bit_o
);

    logic [LFSR_W-1:0] state_q;
    logic              running_q;
    logic              next_bit;

    assign next_bit = prbs7_predict(state_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEED;
            running_q <= 1'b0;
            bit_o     <= 1'b0;
        end else if (!active_i) begin
            running_q <= 1'b0;
            bit_o     <= 1'b0;
        end else if (restart_i) begin
            state_q   <= SEED;
            running_q <= 1'b1;
            bit_o     <= 1'b0;
        end else if (running_q) begin
            state_q   <= prbs7_shift(state_q, next_bit);
            bit_o     <= next_bit;
        end else begin
            bit_o     <= 1'b0;
        end
    end

endmodule

// File: rtl/prbs7_chk.sv
module prbs7_chk
    import prbs7_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic rx_bit_i,
    output logic err_o
);

    localparam int FILL_W = $clog2(LFSR_W + 1);
    localparam logic [FILL_W-1:0] FILL_FULL = FILL_W'(LFSR_W);

    logic [LFSR_W-1:0] hist_q;
    logic [FILL_W-1:0] fill_q;
    logic              synced;

    assign synced = (fill_q == FILL_FULL);
    assign err_o  = active_i && synced && (rx_bit_i != prbs7_predict(hist_q));

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            hist_q <= '0;
            fill_q <= '0;
        end else begin
            hist_q <= prbs7_shift(hist_q, rx_bit_i);
            if (!synced) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prbs7_pulse_seq.sv
module prbs7_pulse_seq
    import prbs7_pkg::*;
#(
    parameter int PEND_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic active_i,
    input  logic err_i,
    output logic pulse_o
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    pulse_phase_t      phase_q, phase_d;
    logic [PEND_W-1:0] pend_q,  pend_d;
    logic              take_pending;
    logic              queue_err;

    always_comb begin
        phase_d      = phase_q;
        take_pending = 1'b0;
        queue_err    = err_i;
        unique case (phase_q)
            PS_IDLE: begin
                if (pend_q != '0) begin
                    phase_d      = PS_HIGH1;
                    take_pending = 1'b1;
                end else if (err_i) begin
                    phase_d   = PS_HIGH1;
                    queue_err = 1'b0;
                end
            end
            PS_HIGH1: phase_d = PS_GAP;
            PS_GAP:   phase_d = PS_HIGH2;
            PS_HIGH2: phase_d = PS_IDLE;
            default:  phase_d = PS_IDLE;
        endcase

        pend_d = pend_q;
        if (take_pending && !queue_err) begin
            pend_d = pend_q - 1'b1;
        end else if (!take_pending && queue_err && pend_q != PEND_MAX) begin
            pend_d = pend_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            phase_q <= PS_IDLE;
            pend_q  <= '0;
        end else begin
            phase_q <= phase_d;
            pend_q  <= pend_d;
        end
    end

    assign pulse_o = (phase_q == PS_HIGH1) || (phase_q == PS_HIGH2);

endmodule

// File: rtl/prbs7_pattern_unit.sv
module prbs7_pattern_unit
    import prbs7_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED   = '1,
    parameter int                PEND_W = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_bit_i,
    input  logic [FIELD_W-1:0] test_en_i,
    input  logic [FIELD_W-1:0] func_sel_i,
    input  logic               start_ctl_i,
    output logic               tx_bit_o,
    output logic               mode_ok_o
);

    mode_sel_t mode;
    logic      start_q;
    logic      start_fall;
    logic      gen_bit;
    logic      chk_err;
    logic      chk_pulse;

    prbs7_mode_dec u_dec (
        .test_en_i  (test_en_i),
        .func_sel_i (func_sel_i),
        .mode_o     (mode)
    );

    // Start control: a high sample followed by a low sample.
    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
        end else begin
            start_q <= start_ctl_i;
        end
    end

    assign start_fall = start_q && !start_ctl_i;

    prbs7_gen #(.SEED(SEED)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .active_i  (mode.gen_on),
        .restart_i (start_fall),
        .bit_o     (gen_bit)
    );

    prbs7_chk u_chk (
        .clk      (clk),
        .rst      (rst),
        .active_i (mode.chk_on),
        .rx_bit_i (rx_bit_i),
        .err_o    (chk_err)
    );

    prbs7_pulse_seq #(.PEND_W(PEND_W)) u_pulse (
        .clk      (clk),
        .rst      (rst),
        .active_i (mode.chk_on),
        .err_i    (chk_err),
        .pulse_o  (chk_pulse)
    );

    always_comb begin
        mode_ok_o = mode.gen_on || mode.chk_on;
        tx_bit_o  = 1'b0;
        if (mode.gen_on) begin
            tx_bit_o = gen_bit;
        end else if (mode.chk_on) begin
            tx_bit_o = chk_pulse;
        end
    end

endmodule

// File: rtl/prbs7_pattern_unit_sva.sv
module prbs7_pattern_unit_sva (
    input logic       clk,
    input logic       rst,
    input logic [2:0] test_en_i,
    input logic [2:0] func_sel_i,
    input logic       tx_bit_o,
    input logic       mode_ok_o
);

    logic gen_sel;
    logic chk_sel;

    assign gen_sel = (test_en_i == 3'd5) && (func_sel_i == 3'd1);
    assign chk_sel = (test_en_i == 3'd5) && (func_sel_i == 3'd4);

    // R1
    mode_flag_chk: assert property (@(posedge clk) disable iff (rst)
        mode_ok_o == (gen_sel || chk_sel));

    // R2
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_ok_o |-> !tx_bit_o);

    // R8
    no_wide_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_sel && $past(chk_sel) && $past(tx_bit_o)) |-> !tx_bit_o);

    // R8
    second_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_sel && $rose(tx_bit_o)) |=> (!chk_sel || !tx_bit_o));

    // R10
    chk_entry_low_chk: assert property (@(posedge clk) disable iff (rst)
        (chk_sel && !$past(chk_sel)) |-> !tx_bit_o);

    // R11
    gen_entry_low_chk: assert property (@(posedge clk) disable iff (rst)
        (gen_sel && !$past(gen_sel)) |-> !tx_bit_o);

endmodule

bind prbs7_pattern_unit prbs7_pattern_unit_sva u_sva (
    .clk        (clk),
    .rst        (rst),
    .test_en_i  (test_en_i),
    .func_sel_i (func_sel_i),
    .tx_bit_o   (tx_bit_o),
    .mode_ok_o  (mode_ok_o)
);

// File: tb/prbs7_pattern_unit_tb_top.sv
module prbs7_pattern_unit_tb_top;

    localparam int CLK_PERIOD_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit;
    logic       start_ctl;
    logic [2:0] test_en;
    logic [2:0] func_sel;
    logic       tx_bit;
    logic       mode_ok;

    int checks = 0;
    int errors = 0;

    prbs7_pattern_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .rx_bit_i    (rx_bit),
        .test_en_i   (test_en),
        .func_sel_i  (func_sel),
        .start_ctl_i (start_ctl),
        .tx_bit_o    (tx_bit),
        .mode_ok_o   (mode_ok)
    );

    always #(CLK_PERIOD_NS/2) clk = ~clk;

    typedef struct {
        logic  tx;
        logic  ok;
        string req;
    } exp_t;

    exp_t sb[$];

    // Reference model state, built from the requirements.
    bit m_prev_start = 0;
    bit m_run = 0;
    bit m_gbit = 0;
    bit gseq[$];
    int m_fill = 0;
    bit m_hist[$];
    int m_pend = 0;
    int m_phase = 0;   // 0 idle, 1 high, 2 gap, 3 high
    bit ref_seq[$];    // independent stream for checker stimulus

    task automatic step(input logic [2:0] e, input logic [2:0] s,
                        input logic st, input logic r, input string req);
        bit g, c, fall, err, nb;
        exp_t x;
        @(negedge clk);
        test_en = e; func_sel = s; start_ctl = st; rx_bit = r;
        g = (e == 3'd5) && (s == 3'd1);
        c = (e == 3'd5) && (s == 3'd4);
        fall = m_prev_start && !st;
        if (!g) begin
            m_run = 0; m_gbit = 0;
        end else if (fall) begin
            gseq.delete();
            for (int i = 0; i < 7; i++) gseq.push_back(1'b1);
            m_run = 1; m_gbit = 0;
        end else if (m_run) begin
            nb = gseq[gseq.size()-6] ^ gseq[gseq.size()-7];
            gseq.push_back(nb);
            if (gseq.size() > 16) void'(gseq.pop_front());
            m_gbit = nb;
        end else begin
            m_gbit = 0;
        end
        m_prev_start = st;
        if (!c) begin
            m_fill = 0; m_hist.delete(); m_pend = 0; m_phase = 0;
        end else begin
            err = (m_fill >= 7) &&
                  (r != (m_hist[m_hist.size()-6] ^ m_hist[m_hist.size()-7]));
            m_hist.push_back(r);
            if (m_hist.size() > 16) void'(m_hist.pop_front());
            if (m_fill < 7) m_fill++;
            case (m_phase)
                0: begin
                    if (m_pend > 0) begin m_phase = 1; m_pend = m_pend - 1 + int'(err); end
                    else if (err) m_phase = 1;
                end
                1: begin m_phase = 2; m_pend += int'(err); end
                2: begin m_phase = 3; m_pend += int'(err); end
                default: begin m_phase = 0; m_pend += int'(err); end
            endcase
        end
        x.ok  = g || c;
        x.tx  = g ? m_gbit : (c ? (m_phase == 1 || m_phase == 3) : 1'b0);
        x.req = req;
        sb.push_back(x);
    endtask

    // Monitor: compares each expected item just after the edge it belongs to.
    initial begin
        forever begin
            exp_t x;
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                x = sb.pop_front();
                checks++;
                if (tx_bit !== x.tx || mode_ok !== x.ok) begin
                    errors++;
                    $display("FAIL %s: tx=%b ok=%b expected tx=%b ok=%b at %0t",
                             x.req, tx_bit, mode_ok, x.tx, x.ok, $time);
                end
            end
        end
    end

    function automatic bit ref_next();
        bit b;
        b = ref_seq[ref_seq.size()-6] ^ ref_seq[ref_seq.size()-7];
        ref_seq.push_back(b);
        if (ref_seq.size() > 16) void'(ref_seq.pop_front());
        return b;
    endfunction

    // Feed n bits of a clean PRBS7 stream; flip the bits whose index is listed.
    task automatic feed_chk(input int n, input int flip_a, input int flip_b, input string req);
        for (int i = 0; i < n; i++) begin
            bit b;
            b = ref_next();
            if (i == flip_a || i == flip_b) b = ~b;
            step(3'd5, 3'd4, 1'b0, b, req);
        end
    endtask

    initial begin
        #(CLK_PERIOD_NS * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        test_en = 3'd0; func_sel = 3'd0; start_ctl = 1'b0; rx_bit = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (tx_bit !== 1'b0 || mode_ok !== 1'b0) begin
            errors++;
            $display("FAIL reset R2: tx=%b ok=%b expected tx=0 ok=0", tx_bit, mode_ok);
        end
        rst = 1'b0;

        // R1 / R2: every control code combination, start held low.
        for (int e = 0; e < 8; e++)
            for (int s = 0; s < 8; s++)
                step(3'(e), 3'(s), 1'b0, 1'b1, "R1");
        step(3'd2, 3'd1, 1'b1, 1'b0, "R2");
        step(3'd2, 3'd1, 1'b0, 1'b0, "R2");

        // R3: generator mode, start high for several cycles produces nothing.
        for (int i = 0; i < 6; i++) step(3'd5, 3'd1, 1'b1, 1'b0, "R3");
        // R4 / R5: high-then-low start, then run beyond one period.
        step(3'd5, 3'd1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 127; i++) step(3'd5, 3'd1, 1'b0, 1'b0, "R4");
        for (int i = 0; i < 140; i++) step(3'd5, 3'd1, 1'b0, 1'b0, "R5");
        // R6: restart during generation.
        step(3'd5, 3'd1, 1'b1, 1'b0, "R6");
        step(3'd5, 3'd1, 1'b0, 1'b0, "R6");
        for (int i = 0; i < 20; i++) step(3'd5, 3'd1, 1'b0, 1'b0, "R6");
        // R11: leave generator mode and return; silent until a new start.
        step(3'd5, 3'd0, 1'b0, 1'b0, "R11");
        for (int i = 0; i < 10; i++) step(3'd5, 3'd1, 1'b0, 1'b0, "R11");
        step(3'd5, 3'd1, 1'b1, 1'b0, "R11");
        step(3'd5, 3'd1, 1'b0, 1'b0, "R11");
        for (int i = 0; i < 15; i++) step(3'd5, 3'd1, 1'b0, 1'b0, "R11");

        // R7: clean stream from a different seed, no errors after lock.
        ref_seq.delete();
        ref_seq.push_back(1'b1);
        for (int i = 0; i < 6; i++) ref_seq.push_back(1'b0);
        feed_chk(60, -1, -1, "R7");
        // R8: one flipped bit (it also disturbs the two predictions that use it).
        feed_chk(40, 5, -1, "R8");
        // R9: two adjacent flips give errors that arrive while pulses run.
        feed_chk(60, 3, 4, "R9");
        // R10: leave during a pulse pair, return and relock.
        feed_chk(3, 1, -1, "R10");
        step(3'd0, 3'd4, 1'b0, 1'b0, "R10");
        feed_chk(30, -1, -1, "R10");
        // R7: a history-only stretch with garbage before lock.
        step(3'd5, 3'd0, 1'b0, 1'b0, "R7");
        for (int i = 0; i < 7; i++) step(3'd5, 3'd4, 1'b0, 1'(i % 3 == 0), "R7");
        for (int i = 0; i < 30; i++) step(3'd5, 3'd4, 1'b0, 1'(i % 2), "R7");

        step(3'd0, 3'd0, 1'b0, 1'b0, "R2");
        @(posedge clk);
        #2;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule